// File: doc/BRIEF.md
# Dual-Port RAM with Per-Port Aspect Ratio

This block is a synchronous true dual-port memory of 4608 bits. It is held as 512 words of nine bits. Each port has its own clock and its own static shape code, so one port can write narrow items while the other reads whole words, or the other way round. The two clocks may be unrelated, or they may be the same net. Every port carries a 12-bit address, 9-bit write data and 9-bit read data. Four control inputs set how the port behaves:

- an active-low block enable;
- an active-low write strobe;
- a read pipeline flag;
- a write-output flag.

Each port presents one request per enabled clock edge. The port accepts every such request, so there is no back-pressure and no ready signal. Read data always comes back after a fixed latency, which depends only on the pipeline flag. The data-out pins therefore act as a stream with a fixed delay and no handshake.

Shape codes, pipeline flags and write-output flags are expected to change only while reset is asserted. The single reset is asynchronous and active low. It clears the output registers of both ports and blocks access to the array, but it leaves the stored data as it was.

Top module: `cardp_dual_ram`

## Requirements
- R1: The 2-bit shape code selects the port's item width and depth: 2'b00 gives 4096 items of 1 bit, 2'b01 gives 2048 items of 2 bits, 2'b10 gives 1024 items of 4 bits, and 2'b11 gives 512 items of 9 bits. An item occupies data bits [w-1:0] on din and dout.
- R2: Narrow items are packed little-endian into the low 8 bits of each word. Item k of width w (1, 2 or 4) sits in word k*w/8, starting at bit (k*w)%8. Bit 8 of a word can be written and read only through the 9-bit shape.
- R3: Address bits above those the shape needs are ignored. These are bit 11 for 2-bit items, bits [11:10] for 4-bit items and bits [11:9] for 9-bit items.
- R4: Bits of dout above the current item width always read 0.
- R5: With the pipeline flag at 0, read data appears on dout after the clock edge that takes the address. With the flag at 1, it appears one edge later.
- R6: On a write with the write-output flag at 0, dout keeps the data of the last read. With the flag at 1, the written item appears on dout with the normal read latency.
- R7: While a port's enable is high, that port neither reads nor writes, and its dout holds its value whatever the address and data inputs do.
- R8: While reset is low, both dout buses are 0 and writes do not reach the array. Data stored before reset can still be read after reset.
- R9: A read on one port in the same edge as a write to the same location from the other port returns the old data. The two ports can write different bits of the same word in the same edge, and both writes take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Clock for port A |
| clk_b | input | 1 | Clock for port B |
| rst_n | input | 1 | Asynchronous reset, active low, shared by both ports |
| shape_a | input | 2 | Shape code for port A |
| shape_b | input | 2 | Shape code for port B |
| pipe_a | input | 1 | Port A adds an extra output register when set |
| pipe_b | input | 1 | Port B adds an extra output register when set |
| wthru_a | input | 1 | Port A shows written data on dout when set |
| wthru_b | input | 1 | Port B shows written data on dout when set |
| en_n_a | input | 1 | Port A enable, active low |
| en_n_b | input | 1 | Port B enable, active low |
| wr_n_a | input | 1 | Port A write strobe: 0 means write, 1 means read |
| wr_n_b | input | 1 | Port B write strobe: 0 means write, 1 means read |
| addr_a | input | 12 | Port A item address |
| addr_b | input | 12 | Port B item address |
| din_a | input | 9 | Port A write data |
| din_b | input | 9 | Port B write data |
| dout_a | output | 9 | Port A read data |
| dout_b | output | 9 | Port B read data |

## Verification
The assertions check the per-port output register on every edge of that port's clock. They cover the following:

- the output holds while the port is disabled;
- the output holds during a write with the write-output flag clear;
- the written item appears during write-through;
- read data arrives after one edge in non-pipelined mode;
- the upper bits of dout stay at zero;
- the output is cleared during reset.

Some behaviours involve both ports or the stored contents, and only the bench scenarios can show them:

- data written at one width and read back at another;
- bit 8 surviving narrow writes;
- old data returned on a cross-port collision;
- two ports writing neighbouring bits of one word in the same edge;
- stored data kept through a reset that blocked a write.

// File: rtl/cardp_pkg.sv
package cardp_pkg;

  // Static per-port shape code; values are decoded by the lane mapper.
  typedef enum logic [1:0] {
    SHAPE_4KX1  = 2'b00,
    SHAPE_2KX2  = 2'b01,
    SHAPE_1KX4  = 2'b10,
    SHAPE_512X9 = 2'b11
  } shape_e;

  // True when the shape covers the whole storage word including its top bit.
  function automatic logic shape_is_wide(logic [1:0] code);
    return shape_e'(code) == SHAPE_512X9;
  endfunction

endpackage

// File: rtl/cardp_lane_map.sv
module cardp_lane_map
  import cardp_pkg::*;
#(
  parameter int WORD_W = 9,
  parameter int IDX_W  = 9,
  parameter int OFF_W  = 3,
  parameter int ADDR_W = 12
) (
  input  logic [1:0]        shape,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] din,
  input  logic [WORD_W-1:0] word_in,
  output logic [IDX_W-1:0]  idx,
  output logic [WORD_W-1:0] wmask,
  output logic [WORD_W-1:0] wword,
  output logic [WORD_W-1:0] item_mask,
  output logic [WORD_W-1:0] rd_item
);

  // Bit position inside the packed narrow lane space.
  localparam int POS_W = IDX_W + OFF_W;

  logic [POS_W-1:0] pos;
  logic [OFF_W-1:0] off;

  always_comb begin
    unique case (shape_e'(shape))
      SHAPE_4KX1: begin
        pos       = addr[POS_W-1:0];
        item_mask = WORD_W'(1);
      end
      SHAPE_2KX2: begin
        pos       = {addr[POS_W-2:0], 1'b0};
        item_mask = WORD_W'(3);
      end
      SHAPE_1KX4: begin
        pos       = {addr[POS_W-3:0], 2'b00};
        item_mask = WORD_W'(15);
      end
      default: begin
        pos       = {addr[IDX_W-1:0], {OFF_W{1'b0}}};
        item_mask = '1;
      end
    endcase
  end

  assign idx     = pos[POS_W-1:OFF_W];
  assign off     = shape_is_wide(shape) ? '0 : pos[OFF_W-1:0];
  assign wmask   = item_mask << off;
  assign wword   = (din & item_mask) << off;
  assign rd_item = (word_in >> off) & item_mask;

endmodule

// File: rtl/cardp_bank.sv
module cardp_bank #(
  parameter int WORDS  = 512,
  parameter int WORD_W = 9,
  parameter int IDX_W  = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [WORD_W-1:0] wmask,
  input  logic [WORD_W-1:0] wdata,
  input  logic [WORD_W-1:0] peer_bits,
  input  logic [IDX_W-1:0]  peer_idx,
  output logic [WORD_W-1:0] q_own,
  output logic [WORD_W-1:0] q_peer
);

  // One bank per port, written only by that port. The stored value is
  // the data XOR the peer bank, so the sum of both banks is the content.
  logic [WORD_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[widx] <= (mem[widx] & ~wmask) | ((wdata ^ peer_bits) & wmask);
    end
  end

  assign q_own  = mem[widx];
  assign q_peer = mem[peer_idx];

endmodule

// File: rtl/cardp_port.sv
module cardp_port #(
  parameter int WORD_W = 9,
  parameter int IDX_W  = 9,
  parameter int OFF_W  = 3,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        shape,
  input  logic              pipe,
  input  logic              wthru,
  input  logic              en_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] din,
  input  logic [WORD_W-1:0] word_in,
  output logic [IDX_W-1:0]  idx,
  output logic              we,
  output logic [WORD_W-1:0] wmask,
  output logic [WORD_W-1:0] wword,
  output logic [WORD_W-1:0] dout
);

  logic [WORD_W-1:0] item_mask;
  logic [WORD_W-1:0] rd_item;
  logic [WORD_W-1:0] s1_q;
  logic [WORD_W-1:0] s2_q;

  cardp_lane_map #(
    .WORD_W(WORD_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W)
  ) u_map (
    .shape    (shape),
    .addr     (addr),
    .din      (din),
    .word_in  (word_in),
    .idx      (idx),
    .wmask    (wmask),
    .wword    (wword),
    .item_mask(item_mask),
    .rd_item  (rd_item)
  );

  assign we = rst_n & ~en_n & ~wr_n;

  // First output register: read data, write-through data, or hold.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
    end else if (!en_n) begin
      if (wr_n) begin
        s1_q <= rd_item;
      end else if (wthru) begin
        s1_q <= din & item_mask;
      end
    end
  end

  // Optional second stage, advancing every edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_q <= '0;
    end else begin
      s2_q <= s1_q;
    end
  end

  assign dout = pipe ? s2_q : s1_q;

  a_r7_disabled_holds: assert property (@(posedge clk) disable iff (!rst_n)
    en_n |=> $stable(s1_q));

  a_r6_hold_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_n && !wr_n && !wthru) |=> $stable(s1_q));

  a_r6_write_through: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_n && !wr_n && wthru) |=> (s1_q == $past(din & item_mask)));

  a_r5_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_n && wr_n && !pipe) |=> (dout == $past(rd_item)));

  a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((dout & ~item_mask) == '0));

  a_r8_reset_clears: assert property (@(posedge clk)
    !rst_n |-> (dout == '0));

endmodule

// File: rtl/cardp_dual_ram.sv
module cardp_dual_ram #(
  parameter int WORDS  = 512,
  parameter int WORD_W = 9,
  parameter int ADDR_W = 12
) (
  input  logic              clk_a,
  input  logic              clk_b,
  input  logic              rst_n,
  input  logic [1:0]        shape_a,
  input  logic [1:0]        shape_b,
  input  logic              pipe_a,
  input  logic              pipe_b,
  input  logic              wthru_a,
  input  logic              wthru_b,
  input  logic              en_n_a,
  input  logic              en_n_b,
  input  logic              wr_n_a,
  input  logic              wr_n_b,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [ADDR_W-1:0] addr_b,
  input  logic [WORD_W-1:0] din_a,
  input  logic [WORD_W-1:0] din_b,
  output logic [WORD_W-1:0] dout_a,
  output logic [WORD_W-1:0] dout_b
);

  localparam int IDX_W   = $clog2(WORDS);
  localparam int OFF_W   = ADDR_W - IDX_W;
  localparam int N_PORTS = 2;

  logic              clk_v   [N_PORTS];
  logic [1:0]        shape_v [N_PORTS];
  logic              pipe_v  [N_PORTS];
  logic              wthru_v [N_PORTS];
  logic              en_n_v  [N_PORTS];
  logic              wr_n_v  [N_PORTS];
  logic [ADDR_W-1:0] addr_v  [N_PORTS];
  logic [WORD_W-1:0] din_v   [N_PORTS];
  logic [WORD_W-1:0] dout_v  [N_PORTS];
  logic [IDX_W-1:0]  idx_v   [N_PORTS];
  logic              we_v    [N_PORTS];
  logic [WORD_W-1:0] wmask_v [N_PORTS];
  logic [WORD_W-1:0] wword_v [N_PORTS];
  logic [WORD_W-1:0] q_own_v [N_PORTS];
  logic [WORD_W-1:0] q_peer_v[N_PORTS];
  logic [WORD_W-1:0] word_v  [N_PORTS];

  assign clk_v[0]   = clk_a;    assign clk_v[1]   = clk_b;
  assign shape_v[0] = shape_a;  assign shape_v[1] = shape_b;
  assign pipe_v[0]  = pipe_a;   assign pipe_v[1]  = pipe_b;
  assign wthru_v[0] = wthru_a;  assign wthru_v[1] = wthru_b;
  assign en_n_v[0]  = en_n_a;   assign en_n_v[1]  = en_n_b;
  assign wr_n_v[0]  = wr_n_a;   assign wr_n_v[1]  = wr_n_b;
  assign addr_v[0]  = addr_a;   assign addr_v[1]  = addr_b;
  assign din_v[0]   = din_a;    assign din_v[1]   = din_b;
  assign dout_a     = dout_v[0];
  assign dout_b     = dout_v[1];

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    localparam int PEER = N_PORTS - 1 - p;

    // Content at this port's word: own bank XOR peer bank at the same index.
    assign word_v[p] = q_own_v[p] ^ q_peer_v[PEER];

    cardp_port #(
      .WORD_W(WORD_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W)
    ) u_port (
      .clk    (clk_v[p]),
      .rst_n  (rst_n),
      .shape  (shape_v[p]),
      .pipe   (pipe_v[p]),
      .wthru  (wthru_v[p]),
      .en_n   (en_n_v[p]),
      .wr_n   (wr_n_v[p]),
      .addr   (addr_v[p]),
      .din    (din_v[p]),
      .word_in(word_v[p]),
      .idx    (idx_v[p]),
      .we     (we_v[p]),
      .wmask  (wmask_v[p]),
      .wword  (wword_v[p]),
      .dout   (dout_v[p])
    );

    cardp_bank #(
      .WORDS(WORDS), .WORD_W(WORD_W), .IDX_W(IDX_W)
    ) u_bank (
      .clk      (clk_v[p]),
      .we       (we_v[p]),
      .widx     (idx_v[p]),
      .wmask    (wmask_v[p]),
      .wdata    (wword_v[p]),
      .peer_bits(q_peer_v[PEER]),
      .peer_idx (idx_v[PEER]),
      .q_own    (q_own_v[p]),
      .q_peer   (q_peer_v[p])
    );
  end

endmodule

// File: tb/tb_cardp_dual_ram.sv
module tb_cardp_dual_ram;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic [1:0] shape_a = 2'b11, shape_b = 2'b11;
  logic       pipe_a = 1'b0, pipe_b = 1'b0, wthru_a = 1'b0, wthru_b = 1'b0;
  logic       en_n_a = 1'b1, en_n_b = 1'b1, wr_n_a = 1'b1, wr_n_b = 1'b1;
  logic [11:0] addr_a = '0, addr_b = '0;
  logic [8:0] din_a = '0, din_b = '0;
  logic [8:0] dout_a, dout_b;

  always #(CLK_PERIOD/2) clk = ~clk;

  cardp_dual_ram dut (
    .clk_a(clk), .clk_b(clk), .rst_n(rst_n),
    .shape_a(shape_a), .shape_b(shape_b),
    .pipe_a(pipe_a), .pipe_b(pipe_b),
    .wthru_a(wthru_a), .wthru_b(wthru_b),
    .en_n_a(en_n_a), .en_n_b(en_n_b),
    .wr_n_a(wr_n_a), .wr_n_b(wr_n_b),
    .addr_a(addr_a), .addr_b(addr_b),
    .din_a(din_a), .din_b(din_b),
    .dout_a(dout_a), .dout_b(dout_b)
  );

  typedef struct {
    int         due;
    logic [8:0] exp;
    string      tag;
  } exp_t;

  exp_t       qa[$];
  exp_t       qb[$];
  int         cyc = 0;
  int         n_tests = 0;
  int         n_fail = 0;
  bit         done = 0;
  logic [8:0] rm [512];
  logic [8:0] s1m [2];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int iw(logic [1:0] s);
    case (s)
      2'b00: return 1;
      2'b01: return 2;
      2'b10: return 4;
      default: return 9;
    endcase
  endfunction

  function automatic logic [8:0] imask(logic [1:0] s);
    return (s == 2'b11) ? 9'h1FF : 9'((1 << iw(s)) - 1);
  endfunction

  function automatic logic [8:0] mread(logic [1:0] s, logic [11:0] a);
    logic [8:0] r = '0;
    int w = iw(s);
    int base;
    if (s == 2'b11) return rm[a[8:0]];
    base = (int'(a) % (4096 / w)) * w;
    for (int i = 0; i < w; i++) r[i] = rm[(base + i) / 8][(base + i) % 8];
    return r;
  endfunction

  task automatic mwrite(logic [1:0] s, logic [11:0] a, logic [8:0] d);
    int w = iw(s);
    int base;
    if (s == 2'b11) begin
      rm[a[8:0]] = d;
    end else begin
      base = (int'(a) % (4096 / w)) * w;
      for (int i = 0; i < w; i++) rm[(base + i) / 8][(base + i) % 8] = d[i];
    end
  endtask

  task automatic check(string port, string tag, logic [8:0] act, logic [8:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s port %s: dout=%h expected %h", tag, port, act, exp);
    end
  endtask

  // Driver: one edge worth of requests on both ports; expected results queued.
  task automatic step(input bit ea, input bit wa, input logic [11:0] aa, input logic [8:0] da,
                      input bit eb, input bit wb, input logic [11:0] ab, input logic [8:0] db,
                      input string tag);
    exp_t e;
    @(negedge clk);
    en_n_a = !ea; wr_n_a = !wa; addr_a = aa; din_a = da;
    en_n_b = !eb; wr_n_b = !wb; addr_b = ab; din_b = db;
    if (ea) begin
      if (!wa) s1m[0] = mread(shape_a, aa);
      else if (wthru_a) s1m[0] = da & imask(shape_a);
    end
    if (eb) begin
      if (!wb) s1m[1] = mread(shape_b, ab);
      else if (wthru_b) s1m[1] = db & imask(shape_b);
    end
    if (ea && wa) mwrite(shape_a, aa, da & imask(shape_a));
    if (eb && wb) mwrite(shape_b, ab, db & imask(shape_b));
    e.tag = tag;
    e.due = cyc + 1 + int'(pipe_a); e.exp = s1m[0]; qa.push_back(e);
    e.due = cyc + 1 + int'(pipe_b); e.exp = s1m[1]; qb.push_back(e);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 12'h000, 9'h000, 0, 0, 12'h000, 9'h000, tag);
  endtask

  // Monitor: compares dout against queued expectations away from the edge.
  always begin
    exp_t e;
    @(posedge clk);
    #(CLK_PERIOD/4);
    if (rst_n && !done) begin
      if (qa.size() > 0 && qa[0].due == cyc) begin
        e = qa.pop_front();
        check("A", e.tag, dout_a, e.exp);
      end
      if (qb.size() > 0 && qb[0].due == cyc) begin
        e = qb.pop_front();
        check("B", e.tag, dout_b, e.exp);
      end
    end
  end

  // Reset with new static configuration; a write attempted during reset must be lost.
  task automatic reset_cfg(input logic [1:0] sa, input logic [1:0] sb,
                           input bit pa, input bit pb, input bit ta, input bit tb_);
    @(negedge clk);
    en_n_a = 1; en_n_b = 1; rst_n = 0;
    qa.delete(); qb.delete();
    #1;
    check("A", "R8 reset clears", dout_a, 9'h000);
    check("B", "R8 reset clears", dout_b, 9'h000);
    shape_a = sa; shape_b = sb; pipe_a = pa; pipe_b = pb; wthru_a = ta; wthru_b = tb_;
    en_n_a = 0; wr_n_a = 0; addr_a = 12'h010; din_a = 9'h1AB;
    en_n_b = 0; wr_n_b = 0; addr_b = 12'h041; din_b = 9'h1FF;
    @(negedge clk);
    @(negedge clk);
    check("A", "R8 held in reset", dout_a, 9'h000);
    check("B", "R8 held in reset", dout_b, 9'h000);
    en_n_a = 1; en_n_b = 1; wr_n_a = 1; wr_n_b = 1;
    rst_n = 1;
    s1m[0] = '0; s1m[1] = '0;
  endtask

  initial begin
    #1 rst_n = 0;
    reset_cfg(2'b11, 2'b11, 0, 0, 0, 0);
    for (int w = 0; w < 512; w++) step(1, 1, 12'(w), 9'h000, 0, 0, 12'h000, 9'h000, "init");
    idle("R7 idle");

    // Phase 1: A 1024x4 non-pipelined, B 4096x1 pipelined.
    reset_cfg(2'b10, 2'b00, 0, 1, 0, 0);
    for (int k = 0; k < 16; k++) step(1, 1, 12'(k), 9'((k * 5 + 3) & 15), 0, 0, 12'h000, 9'h000, "R1 R6 write x4");
    for (int b = 0; b < 64; b++) step(0, 0, 12'h000, 9'h000, 1, 0, 12'(b), 9'h000, "R2 R5 x1 pipelined read");
    for (int k = 0; k < 16; k++) step(1, 0, 12'(k), 9'h000, 0, 0, 12'h000, 9'h000, "R1 R5 x4 read");
    step(1, 0, 12'h003, 9'h000, 0, 0, 12'h000, 9'h000, "R5 read item 3");
    step(1, 1, 12'h014, 9'h00A, 0, 0, 12'h000, 9'h000, "R6 hold on write");
    step(1, 0, 12'h014, 9'h000, 0, 0, 12'h000, 9'h000, "R6 read back");
    step(1, 0, 12'h001, 9'h000, 0, 0, 12'h000, 9'h000, "R5 read item 1");
    for (int i = 0; i < 4; i++) step(0, 1, 12'(i + 7), 9'h00F, 0, 1, 12'(i), 9'h001, "R7 disabled holds");
    step(1, 0, 12'h007, 9'h000, 0, 0, 12'h000, 9'h000, "R7 no write while disabled");
    step(1, 0, 12'hC05, 9'h000, 0, 0, 12'h000, 9'h000, "R3 high address bits x4");
    idle("R7 idle");

    // Phase 2: A 512x9 pipelined write-through, B 2048x2 non-pipelined write-through.
    reset_cfg(2'b11, 2'b01, 1, 0, 1, 1);
    step(1, 0, 12'h010, 9'h000, 0, 0, 12'h000, 9'h000, "R8 write blocked in reset");
    step(1, 0, 12'h002, 9'h000, 1, 0, 12'h104, 9'h000, "R8 contents kept");
    step(1, 1, 12'h030, 9'h1C6, 0, 0, 12'h000, 9'h000, "R6 R5 write-through pipelined");
    for (int k = 0; k < 4; k++) step(0, 0, 12'h000, 9'h000, 1, 0, 12'(12'h0C0 + k), 9'h000, "R2 R4 x2 read of wide word");
    step(0, 0, 12'h000, 9'h000, 1, 1, 12'h0C5, 9'h002, "R6 write-through x2");
    step(1, 0, 12'h031, 9'h000, 0, 0, 12'h000, 9'h000, "R2 wide read of x2 write");
    step(1, 0, 12'hE31, 9'h000, 1, 0, 12'h8C5, 9'h000, "R3 high address bits x9 x2");
    step(1, 1, 12'h040, 9'h0FF, 1, 0, 12'h100, 9'h000, "R9 collision returns old");
    step(0, 0, 12'h000, 9'h000, 1, 0, 12'h100, 9'h000, "R9 new data after collision");
    idle("R7 idle");
    idle("R7 idle");

    // Phase 3: both 4096x1; neighbouring bits of one word written together.
    reset_cfg(2'b00, 2'b00, 0, 0, 0, 0);
    step(1, 1, 12'h280, 9'h001, 1, 1, 12'h281, 9'h001, "R9 same-word dual write");
    step(1, 1, 12'h180, 9'h001, 0, 0, 12'h000, 9'h000, "R2 narrow write near bit 8");
    step(1, 0, 12'h281, 9'h000, 1, 0, 12'h280, 9'h000, "R9 both bits landed");
    idle("R7 idle");

    // Phase 4: A 512x9, B 1024x4; bit 8 survives narrow writes.
    reset_cfg(2'b11, 2'b10, 0, 0, 0, 0);
    step(1, 0, 12'h030, 9'h000, 1, 0, 12'h060, 9'h000, "R2 bit 8 intact, R4 x4 low nibble");
    step(1, 0, 12'h050, 9'h000, 1, 0, 12'h061, 9'h000, "R9 dual write word, R4 x4 high nibble");
    idle("R7 idle");
    idle("R7 idle");
    idle("R7 idle");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog (all requirements): still running at cycle %0d, expected finish", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule